// File: doc/BRIEF.md
# Transactional Read/Write-Set Tracker

This block runs beside the tag array of a small direct-mapped cache in one core. It keeps a mirror of each line's valid bit, tag and dirty bit, and adds two speculative marks per line: a read mark and a write mark. Versioning is lazy, so speculative stores change only the local copy. Conflict detection is also lazy, so other cores see nothing until this core commits. Transactional loads set the read mark. Transactional stores set the write mark.

A snooped invalidation that hits a read-marked line ends the transaction with a conflict abort. So does the loss of a write-marked line, which is an overflow abort. An explicit request from the core also aborts. On any abort, every written line is dropped, all marks are cleared, and the core restarts the transaction.

At transaction end the block raises a commit request and waits for a grant from the central arbiter. It then streams the address of every written line over a valid/ready channel. After the last address it spends one cycle clearing all marks at once. Committed lines stay dirty and are written back only when they later leave the cache.

The controller has five states:
- `ST_IDLE`: no transaction. Accesses only maintain tags and dirty bits.
- `ST_RUN`: transaction in progress.
- `ST_WAIT`: commit requested, no grant yet.
- `ST_SEND`: granted, address stream running.
- `ST_FLUSH`: single clear cycle.

Transitions:
- IDLE→RUN on begin.
- RUN→WAIT on end.
- RUN→IDLE and WAIT→IDLE on abort.
- WAIT→SEND on grant.
- SEND→FLUSH when the last written address is accepted, or at once if nothing was written.
- FLUSH→IDLE always.

Top module: `tmt_tracker`

## Requirements
- R1: In `ST_RUN`, a load sets the read mark of its line. On a miss it first installs the line clean. A later snoop to that line address then aborts.
- R2: In `ST_RUN`, a store sets the write mark and makes nothing visible. `cm_valid` stays 0 and `commit_req` stays 0 until end, and no write-back is issued for the new data. If the hit line held older dirty data, that older line address is written back first.
- R3: Losing a write-marked line while a transaction is live raises `abort_flag` with `abort_cause` = 2'b01 (overflow). This covers an `evict_valid` to its index and a miss that would replace it.
- R4: On any abort, written lines are invalidated and all marks are cleared. A later eviction of such a line gives no write-back. `abort_flag` and `abort_cause` hold until the next accepted `tx_begin`, which clears both to 0.
- R5: In `ST_RUN` or `ST_WAIT`, a snoop whose address hits a valid read-marked line aborts with cause 2'b10 (conflict). In `ST_SEND` a snoop has no effect. A snoop that only matches the index but not the tag has no effect.
- R6: `tx_end` in `ST_RUN` raises `commit_req` and holds it until `commit_grant`. In `ST_SEND`, the full line address {tag, index} of each written line is offered once, in ascending index order. The address holds stable while `cm_ready` is low.
- R7: Committed lines, and lines stored outside a transaction, are dirty. When such a line is evicted or replaced, `wb_valid` pulses for one cycle with its line address, in the cycle after the event.
- R8: After the last address is accepted, `commit_done` is high for exactly one cycle and the block then returns to idle with every mark cleared. A commit with no written lines goes straight from `ST_SEND` to `ST_FLUSH`.
- R9: Loads and stores in `ST_IDLE` set no marks and never abort.
- R10: `tx_abort` in `ST_RUN` or `ST_WAIT` gives cause 2'b11. When causes coincide, overflow beats conflict and conflict beats explicit.
- R11: After reset `abort_flag`, `abort_cause`, `commit_req`, `cm_valid`, `commit_done` and `wb_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_begin | input | 1 | Start a transaction (accepted in idle) |
| tx_end | input | 1 | Transaction reached its end |
| tx_abort | input | 1 | Explicit abort request |
| acc_valid | input | 1 | Core access this cycle |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | LA_W | Line address of the access |
| evict_valid | input | 1 | Cache evicts a line this cycle |
| evict_idx | input | IDX_W | Index of the evicted line |
| snoop_valid | input | 1 | Bus invalidation observed |
| snoop_addr | input | LA_W | Line address of the invalidation |
| abort_flag | output | 1 | Transaction aborted (held) |
| abort_cause | output | 2 | 01 overflow, 10 conflict, 11 explicit |
| commit_req | output | 1 | Request to the commit arbiter |
| commit_grant | input | 1 | Arbiter grant |
| cm_valid | output | 1 | Commit address valid |
| cm_ready | input | 1 | Commit address accepted |
| cm_addr | output | LA_W | Written line address being broadcast |
| commit_done | output | 1 | One-cycle pulse in the clear cycle |
| wb_valid | output | 1 | Write-back request pulse |
| wb_addr | output | LA_W | Line address to write back |

## Verification
The bench builds the block with 8 lines and a 10-bit line address, so each tag is 7 bits. Two addresses that differ by a multiple of 8 therefore collide on one index. This makes it easy to drive replacement overflow, tag-mismatch snoops, and write-back of a committed line that a new tag displaces. With only 8 lines, a commit with two written lines at indices 2 and 5 exercises ascending order, a stall, and the last-address shortcut into the clear cycle.

// File: rtl/tmt_pkg.sv
package tmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_WAIT,
        ST_SEND,
        ST_FLUSH
    } tmt_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_OVERFLOW = 2'b01,
        CAUSE_CONFLICT = 2'b10,
        CAUSE_EXPLICIT = 2'b11
    } tmt_cause_e;

endpackage

// File: rtl/tmt_first_set.sv
module tmt_first_set #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);
    // Lowest set bit wins: the loop runs downward so the last hit kept is the lowest.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end

    assign found = |req;

endmodule

// File: rtl/tmt_lines.sv
module tmt_lines #(
    parameter int LINES = 8,
    parameter int LA_W  = 12,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = LA_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LA_W-1:0]  acc_addr,
    input  logic [IDX_W-1:0] evict_idx,
    input  logic [LA_W-1:0]  snoop_addr,
    input  logic             cmd_acc,
    input  logic             acc_mark_rd,
    input  logic             acc_mark_wr,
    input  logic             acc_dirty,
    input  logic             cmd_evict,
    input  logic             cmd_abort,
    input  logic             cmd_retire,
    input  logic             cmd_flash,
    output logic             acc_hit,
    output logic             acc_line_valid,
    output logic             acc_line_wr,
    output logic             acc_line_dirty,
    output logic [TAG_W-1:0] acc_line_tag,
    output logic             ev_line_valid,
    output logic             ev_line_wr,
    output logic             ev_line_dirty,
    output logic [TAG_W-1:0] ev_line_tag,
    output logic             snoop_rd_hit,
    output logic             any_wr,
    output logic             wr_single,
    output logic [LA_W-1:0]  head_addr
);
    logic [LINES-1:0]       vld, rdm, wrm, dty;
    logic [LINES*TAG_W-1:0] tag_flat;
    logic [IDX_W-1:0]       acc_idx, snp_idx, head_idx;
    logic [TAG_W-1:0]       acc_tag, snp_tag, head_tag, snp_line_tag;

    assign acc_idx = acc_addr[IDX_W-1:0];
    assign acc_tag = acc_addr[LA_W-1:IDX_W];
    assign snp_idx = snoop_addr[IDX_W-1:0];
    assign snp_tag = snoop_addr[LA_W-1:IDX_W];

    tmt_first_set #(.N(LINES)) u_head (
        .req   (wrm),
        .found (any_wr),
        .idx   (head_idx)
    );

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic             v_q, r_q, w_q, d_q;
            logic [TAG_W-1:0] t_q;
            logic             sel_acc, sel_ev, sel_ret, hit_g;

            assign sel_acc = cmd_acc    && (acc_idx   == IDX_W'(g));
            assign sel_ev  = cmd_evict  && (evict_idx == IDX_W'(g));
            assign sel_ret = cmd_retire && (head_idx  == IDX_W'(g));
            assign hit_g   = v_q && (t_q == acc_tag);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    r_q <= 1'b0;
                    w_q <= 1'b0;
                    d_q <= 1'b0;
                    t_q <= '0;
                end else if (cmd_abort) begin
                    if (w_q) begin
                        v_q <= 1'b0;
                        d_q <= 1'b0;
                    end
                    r_q <= 1'b0;
                    w_q <= 1'b0;
                end else if (cmd_flash) begin
                    r_q <= 1'b0;
                    w_q <= 1'b0;
                end else if (sel_ret) begin
                    w_q <= 1'b0;
                    d_q <= 1'b1;
                end else if (sel_ev) begin
                    v_q <= 1'b0;
                    r_q <= 1'b0;
                    w_q <= 1'b0;
                    d_q <= 1'b0;
                end else if (sel_acc) begin
                    if (hit_g) begin
                        r_q <= r_q | acc_mark_rd;
                        w_q <= w_q | acc_mark_wr;
                        d_q <= acc_mark_wr ? 1'b0 : (d_q | acc_dirty);
                    end else begin
                        v_q <= 1'b1;
                        t_q <= acc_tag;
                        r_q <= acc_mark_rd;
                        w_q <= acc_mark_wr;
                        d_q <= acc_dirty;
                    end
                end
            end

            assign vld[g] = v_q;
            assign rdm[g] = r_q;
            assign wrm[g] = w_q;
            assign dty[g] = d_q;
            assign tag_flat[g*TAG_W +: TAG_W] = t_q;

            // R2: a write mark only ever sits on a line that is present
            a_r2_mark_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
                w_q |-> v_q);
        end
    endgenerate

    assign acc_line_tag   = tag_flat[acc_idx*TAG_W +: TAG_W];
    assign acc_line_valid = vld[acc_idx];
    assign acc_line_wr    = wrm[acc_idx];
    assign acc_line_dirty = dty[acc_idx];
    assign acc_hit        = acc_line_valid && (acc_line_tag == acc_tag);

    assign ev_line_tag    = tag_flat[evict_idx*TAG_W +: TAG_W];
    assign ev_line_valid  = vld[evict_idx];
    assign ev_line_wr     = wrm[evict_idx];
    assign ev_line_dirty  = dty[evict_idx];

    assign snp_line_tag   = tag_flat[snp_idx*TAG_W +: TAG_W];
    assign snoop_rd_hit   = vld[snp_idx] && rdm[snp_idx] && (snp_line_tag == snp_tag);

    assign head_tag       = tag_flat[head_idx*TAG_W +: TAG_W];
    assign head_addr      = {head_tag, head_idx};
    assign wr_single      = any_wr && ((wrm & (wrm - LINES'(1))) == '0);

endmodule

// File: rtl/tmt_ctrl.sv
module tmt_ctrl
    import tmt_pkg::*;
#(
    parameter int LINES = 8,
    parameter int LA_W  = 12,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = LA_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_begin,
    input  logic             tx_end,
    input  logic             tx_abort,
    input  logic             acc_valid,
    input  logic             acc_store,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             evict_valid,
    input  logic [IDX_W-1:0] evict_idx,
    input  logic             snoop_valid,
    input  logic             commit_grant,
    input  logic             cm_ready,
    input  logic             acc_hit,
    input  logic             acc_line_valid,
    input  logic             acc_line_wr,
    input  logic             acc_line_dirty,
    input  logic [TAG_W-1:0] acc_line_tag,
    input  logic             ev_line_valid,
    input  logic             ev_line_wr,
    input  logic             ev_line_dirty,
    input  logic [TAG_W-1:0] ev_line_tag,
    input  logic             snoop_rd_hit,
    input  logic             any_wr,
    input  logic             wr_single,
    input  logic [LA_W-1:0]  head_addr,
    output logic             cmd_acc,
    output logic             acc_mark_rd,
    output logic             acc_mark_wr,
    output logic             acc_dirty,
    output logic             cmd_evict,
    output logic             cmd_abort,
    output logic             cmd_retire,
    output logic             cmd_flash,
    output logic             abort_flag,
    output logic [1:0]       abort_cause,
    output logic             commit_req,
    output logic             cm_valid,
    output logic [LA_W-1:0]  cm_addr,
    output logic             commit_done,
    output logic             wb_valid,
    output logic [LA_W-1:0]  wb_addr
);
    tmt_state_e state_q, state_d;
    tmt_cause_e cause_now;
    logic       in_tx, ovf_acc, ovf_ev, conflict, expl, abort_now;
    logic       wb_acc, wb_ev;

    assign in_tx    = (state_q == ST_RUN) || (state_q == ST_WAIT);
    assign ovf_acc  = (state_q == ST_RUN) && acc_valid && !evict_valid &&
                      acc_line_valid && !acc_hit && acc_line_wr;
    assign ovf_ev   = in_tx && evict_valid && ev_line_wr;
    assign conflict = in_tx && snoop_valid && snoop_rd_hit;
    assign expl     = in_tx && tx_abort;
    assign abort_now = ovf_acc || ovf_ev || conflict || expl;

    always_comb begin
        if (ovf_acc || ovf_ev) cause_now = CAUSE_OVERFLOW;
        else if (conflict)     cause_now = CAUSE_CONFLICT;
        else if (expl)         cause_now = CAUSE_EXPLICIT;
        else                   cause_now = CAUSE_NONE;
    end

    // Command decode towards the line store
    always_comb begin
        cmd_acc     = acc_valid && !evict_valid && !abort_now &&
                      ((state_q == ST_IDLE) || (state_q == ST_RUN));
        acc_mark_rd = (state_q == ST_RUN) && !acc_store;
        acc_mark_wr = (state_q == ST_RUN) && acc_store;
        acc_dirty   = (state_q == ST_IDLE) && acc_store;
        cmd_evict   = evict_valid && !abort_now &&
                      ((state_q == ST_IDLE) || in_tx);
        cmd_abort   = abort_now;
        cmd_retire  = (state_q == ST_SEND) && any_wr && cm_ready;
        cmd_flash   = (state_q == ST_FLUSH);
        wb_acc      = cmd_acc && acc_line_valid && acc_line_dirty &&
                      (!acc_hit || acc_mark_wr);
        wb_ev       = cmd_evict && ev_line_valid && ev_line_dirty;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tx_begin) state_d = ST_RUN;
            ST_RUN: begin
                if (abort_now)   state_d = ST_IDLE;
                else if (tx_end) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (abort_now)         state_d = ST_IDLE;
                else if (commit_grant) state_d = ST_SEND;
            end
            ST_SEND: begin
                if (!any_wr)                      state_d = ST_FLUSH;
                else if (cmd_retire && wr_single) state_d = ST_FLUSH;
            end
            ST_FLUSH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abort_flag  <= 1'b0;
            abort_cause <= CAUSE_NONE;
            wb_valid    <= 1'b0;
            wb_addr     <= '0;
        end else begin
            if ((state_q == ST_IDLE) && tx_begin) begin
                abort_flag  <= 1'b0;
                abort_cause <= CAUSE_NONE;
            end else if (abort_now) begin
                abort_flag  <= 1'b1;
                abort_cause <= cause_now;
            end
            wb_valid <= wb_acc || wb_ev;
            if (wb_ev)       wb_addr <= {ev_line_tag, evict_idx};
            else if (wb_acc) wb_addr <= {acc_line_tag, acc_idx};
        end
    end

    assign commit_req  = (state_q == ST_WAIT);
    assign cm_valid    = (state_q == ST_SEND) && any_wr;
    assign cm_addr     = head_addr;
    assign commit_done = (state_q == ST_FLUSH);

    // R6: a stalled address stays put
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && !cm_ready) |=> (cm_valid && $stable(cm_addr)));

    // R4: abort indication is held until a new transaction is accepted
    a_r4_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_flag && !tx_begin) |=> (abort_flag && $stable(abort_cause)));

    // R5: once granted, nothing can abort the commit
    a_r5_no_abort_in_send: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND) |=> !$rose(abort_flag));

    // R9: no abort can arise outside a transaction
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !abort_flag) |=> !abort_flag);

    // R8: the clear cycle lasts one cycle and lands in idle
    a_r8_flush_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |=> (!commit_done && !commit_req && state_q == ST_IDLE));

    // R6: no address is offered while the request is pending
    a_r6_req_excl: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |-> !cm_valid);

endmodule

// File: rtl/tmt_tracker.sv
module tmt_tracker #(
    parameter int LINES = 8,
    parameter int LA_W  = 12,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = LA_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_begin,
    input  logic             tx_end,
    input  logic             tx_abort,
    input  logic             acc_valid,
    input  logic             acc_store,
    input  logic [LA_W-1:0]  acc_addr,
    input  logic             evict_valid,
    input  logic [IDX_W-1:0] evict_idx,
    input  logic             snoop_valid,
    input  logic [LA_W-1:0]  snoop_addr,
    output logic             abort_flag,
    output logic [1:0]       abort_cause,
    output logic             commit_req,
    input  logic             commit_grant,
    output logic             cm_valid,
    input  logic             cm_ready,
    output logic [LA_W-1:0]  cm_addr,
    output logic             commit_done,
    output logic             wb_valid,
    output logic [LA_W-1:0]  wb_addr
);
    logic             cmd_acc, acc_mark_rd, acc_mark_wr, acc_dirty;
    logic             cmd_evict, cmd_abort, cmd_retire, cmd_flash;
    logic             acc_hit, acc_line_valid, acc_line_wr, acc_line_dirty;
    logic [TAG_W-1:0] acc_line_tag, ev_line_tag;
    logic             ev_line_valid, ev_line_wr, ev_line_dirty;
    logic             snoop_rd_hit, any_wr, wr_single;
    logic [LA_W-1:0]  head_addr;

    tmt_lines #(.LINES(LINES), .LA_W(LA_W)) u_lines (
        .clk            (clk),
        .rst_n          (rst_n),
        .acc_addr       (acc_addr),
        .evict_idx      (evict_idx),
        .snoop_addr     (snoop_addr),
        .cmd_acc        (cmd_acc),
        .acc_mark_rd    (acc_mark_rd),
        .acc_mark_wr    (acc_mark_wr),
        .acc_dirty      (acc_dirty),
        .cmd_evict      (cmd_evict),
        .cmd_abort      (cmd_abort),
        .cmd_retire     (cmd_retire),
        .cmd_flash      (cmd_flash),
        .acc_hit        (acc_hit),
        .acc_line_valid (acc_line_valid),
        .acc_line_wr    (acc_line_wr),
        .acc_line_dirty (acc_line_dirty),
        .acc_line_tag   (acc_line_tag),
        .ev_line_valid  (ev_line_valid),
        .ev_line_wr     (ev_line_wr),
        .ev_line_dirty  (ev_line_dirty),
        .ev_line_tag    (ev_line_tag),
        .snoop_rd_hit   (snoop_rd_hit),
        .any_wr         (any_wr),
        .wr_single      (wr_single),
        .head_addr      (head_addr)
    );

    tmt_ctrl #(.LINES(LINES), .LA_W(LA_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_begin       (tx_begin),
        .tx_end         (tx_end),
        .tx_abort       (tx_abort),
        .acc_valid      (acc_valid),
        .acc_store      (acc_store),
        .acc_idx        (acc_addr[IDX_W-1:0]),
        .evict_valid    (evict_valid),
        .evict_idx      (evict_idx),
        .snoop_valid    (snoop_valid),
        .commit_grant   (commit_grant),
        .cm_ready       (cm_ready),
        .acc_hit        (acc_hit),
        .acc_line_valid (acc_line_valid),
        .acc_line_wr    (acc_line_wr),
        .acc_line_dirty (acc_line_dirty),
        .acc_line_tag   (acc_line_tag),
        .ev_line_valid  (ev_line_valid),
        .ev_line_wr     (ev_line_wr),
        .ev_line_dirty  (ev_line_dirty),
        .ev_line_tag    (ev_line_tag),
        .snoop_rd_hit   (snoop_rd_hit),
        .any_wr         (any_wr),
        .wr_single      (wr_single),
        .head_addr      (head_addr),
        .cmd_acc        (cmd_acc),
        .acc_mark_rd    (acc_mark_rd),
        .acc_mark_wr    (acc_mark_wr),
        .acc_dirty      (acc_dirty),
        .cmd_evict      (cmd_evict),
        .cmd_abort      (cmd_abort),
        .cmd_retire     (cmd_retire),
        .cmd_flash      (cmd_flash),
        .abort_flag     (abort_flag),
        .abort_cause    (abort_cause),
        .commit_req     (commit_req),
        .cm_valid       (cm_valid),
        .cm_addr        (cm_addr),
        .commit_done    (commit_done),
        .wb_valid       (wb_valid),
        .wb_addr        (wb_addr)
    );

endmodule

// File: tb/sim_tmt_tracker.sv
module sim_tmt_tracker;
    localparam int LINES = 8;
    localparam int LA_W  = 10;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tx_begin = 0, tx_end = 0, tx_abort = 0;
    logic             acc_valid = 0, acc_store = 0;
    logic [LA_W-1:0]  acc_addr = '0;
    logic             evict_valid = 0;
    logic [IDX_W-1:0] evict_idx = '0;
    logic             snoop_valid = 0;
    logic [LA_W-1:0]  snoop_addr = '0;
    logic             commit_grant = 0, cm_ready = 0;
    logic             abort_flag, commit_req, cm_valid, commit_done, wb_valid;
    logic [1:0]       abort_cause;
    logic [LA_W-1:0]  cm_addr, wb_addr;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tmt_tracker #(.LINES(LINES), .LA_W(LA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_end(tx_end),
        .tx_abort(tx_abort), .acc_valid(acc_valid), .acc_store(acc_store),
        .acc_addr(acc_addr), .evict_valid(evict_valid), .evict_idx(evict_idx),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .abort_flag(abort_flag), .abort_cause(abort_cause),
        .commit_req(commit_req), .commit_grant(commit_grant),
        .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_addr(cm_addr),
        .commit_done(commit_done), .wb_valid(wb_valid), .wb_addr(wb_addr)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // inputs change 1 ns after a rising edge, results are read there too
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic op_begin();
        tx_begin = 1; cyc(); tx_begin = 0;
    endtask
    task automatic op_end();
        tx_end = 1; cyc(); tx_end = 0;
    endtask
    task automatic op_abort();
        tx_abort = 1; cyc(); tx_abort = 0;
    endtask
    task automatic op_acc(input logic st, input int a);
        acc_valid = 1; acc_store = st; acc_addr = LA_W'(a); cyc();
        acc_valid = 0; acc_store = 0;
    endtask
    task automatic op_snoop(input int a);
        snoop_valid = 1; snoop_addr = LA_W'(a); cyc(); snoop_valid = 0;
    endtask
    task automatic op_evict(input int i);
        evict_valid = 1; evict_idx = IDX_W'(i); cyc(); evict_valid = 0;
    endtask

    task automatic t_reset();
        chk("R11", "abort_flag", int'(abort_flag), 0);
        chk("R11", "abort_cause", int'(abort_cause), 0);
        chk("R11", "commit_req", int'(commit_req), 0);
        chk("R11", "cm_valid", int'(cm_valid), 0);
        chk("R11", "commit_done", int'(commit_done), 0);
        chk("R11", "wb_valid", int'(wb_valid), 0);
    endtask

    task automatic t_idle_access();
        op_acc(0, 'h01);
        op_acc(1, 'h09);
        chk("R9", "no wb on clean replace", int'(wb_valid), 0);
        op_snoop('h09);
        chk("R9", "idle snoop no abort", int'(abort_flag), 0);
        op_evict(1);
        chk("R7", "wb after idle store", int'(wb_valid), 1);
        chk("R7", "wb addr", int'(wb_addr), 'h09);
        cyc();
        chk("R7", "wb one cycle", int'(wb_valid), 0);
    endtask

    task automatic t_load_conflict();
        op_begin();
        op_acc(0, 'h13);
        op_snoop('h0B);
        chk("R5", "tag mismatch snoop ignored", int'(abort_flag), 0);
        op_snoop('h13);
        chk("R1", "read mark conflict", int'(abort_flag), 1);
        chk("R5", "conflict cause", int'(abort_cause), 2);
        cyc(); cyc();
        chk("R4", "cause held", int'(abort_cause), 2);
        op_begin();
        chk("R4", "begin clears flag", int'(abort_flag), 0);
        chk("R4", "begin clears cause", int'(abort_cause), 0);
        op_abort();
        chk("R10", "explicit cause", int'(abort_cause), 3);
    endtask

    task automatic t_commit();
        op_begin();
        op_acc(1, 'h15);
        chk("R2", "no wb for spec store", int'(wb_valid), 0);
        chk("R2", "no stream before end", int'(cm_valid), 0);
        op_acc(1, 'h0A);
        op_acc(0, 'h03);
        chk("R2", "no request before end", int'(commit_req), 0);
        op_end();
        chk("R6", "commit_req raised", int'(commit_req), 1);
        chk("R6", "no stream before grant", int'(cm_valid), 0);
        cyc();
        chk("R6", "commit_req held", int'(commit_req), 1);
        commit_grant = 1; cyc(); commit_grant = 0;
        chk("R6", "first addr valid", int'(cm_valid), 1);
        chk("R6", "first addr lowest index", int'(cm_addr), 'h0A);
        cyc();
        chk("R6", "stalled addr stable", int'(cm_addr), 'h0A);
        cm_ready = 1; cyc();
        chk("R6", "second addr", int'(cm_addr), 'h15);
        cyc(); cm_ready = 0;
        chk("R8", "done pulse", int'(commit_done), 1);
        chk("R8", "stream ended", int'(cm_valid), 0);
        cyc();
        chk("R8", "done one cycle", int'(commit_done), 0);
        chk("R8", "back idle", int'(commit_req), 0);
        op_begin();
        op_snoop('h03);
        chk("R8", "read marks cleared", int'(abort_flag), 0);
        op_end();
        commit_grant = 1; cyc(); commit_grant = 0;
        chk("R8", "empty commit no addr", int'(cm_valid), 0);
        cyc();
        chk("R8", "empty commit done", int'(commit_done), 1);
        cyc();
        op_evict(5);
        chk("R7", "committed line written back", int'(wb_valid), 1);
        chk("R7", "committed wb addr", int'(wb_addr), 'h15);
    endtask

    task automatic t_store_dirty();
        op_begin();
        op_acc(1, 'h0A);
        chk("R2", "old dirty data flushed first", int'(wb_valid), 1);
        chk("R2", "old dirty addr", int'(wb_addr), 'h0A);
        op_abort();
        op_evict(2);
        chk("R4", "aborted written line dropped", int'(wb_valid), 0);
    endtask

    task automatic t_overflow();
        op_begin();
        op_acc(1, 'h22);
        op_evict(2);
        chk("R3", "evict overflow flag", int'(abort_flag), 1);
        chk("R3", "evict overflow cause", int'(abort_cause), 1);
        op_begin();
        op_acc(1, 'h23);
        op_acc(0, 'h2B);
        chk("R3", "replace overflow flag", int'(abort_flag), 1);
        chk("R3", "replace overflow cause", int'(abort_cause), 1);
    endtask

    task automatic t_snoop_phases();
        op_begin();
        op_acc(0, 'h04);
        op_end();
        op_snoop('h04);
        chk("R5", "snoop while waiting aborts", int'(abort_cause), 2);
        chk("R5", "request dropped", int'(commit_req), 0);
        op_begin();
        op_acc(0, 'h04);
        op_acc(1, 'h0F);
        op_end();
        commit_grant = 1; cyc(); commit_grant = 0;
        op_snoop('h04);
        chk("R5", "snoop during send ignored", int'(abort_flag), 0);
        chk("R6", "stream addr", int'(cm_addr), 'h0F);
        cm_ready = 1; cyc(); cm_ready = 0;
        chk("R8", "single line done", int'(commit_done), 1);
        cyc();
    endtask

    task automatic t_priority();
        op_begin();
        op_acc(0, 'h04);
        snoop_valid = 1; snoop_addr = 'h04; tx_abort = 1; cyc();
        snoop_valid = 0; tx_abort = 0;
        chk("R10", "conflict beats explicit", int'(abort_cause), 2);
        op_begin();
        op_acc(1, 'h06);
        op_acc(0, 'h07);
        evict_valid = 1; evict_idx = 6; snoop_valid = 1; snoop_addr = 'h07;
        tx_abort = 1; cyc();
        evict_valid = 0; snoop_valid = 0; tx_abort = 0;
        chk("R10", "overflow beats all", int'(abort_cause), 1);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        cyc(); cyc();
        rst_n = 1;
        cyc();
        t_idle_access();
        t_load_conflict();
        t_commit();
        t_store_dirty();
        t_overflow();
        t_snoop_phases();
        t_priority();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule